// File: doc/BRIEF.md
# JK Sequence Counter with Unused-State Recovery

This block is a three-bit synchronous counter whose state bits are held in three JK-style flip-flops. It does not count in binary. Its main loop visits the codes 2, 6, 1, 7 and 5, then returns to 2. The next state comes only from a fixed set of J and K input equations, so the three codes outside the loop (0, 3 and 4) also have defined successors. Those successors lead back into the loop within at most two clocks. No decode forces them there.

The block has only a clock and an active-high synchronous reset as inputs. The outputs are the three state bits, with A as the most significant, then B, then C. The parameter `RESET_CODE` sets the code that reset loads. It defaults to 2 (binary 010), which is the entry point of the main loop. Setting it to another code is how a fresh start from any state can be reached, including the unused ones.

Top module: `jkc_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes `RESET_CODE` (default 2: A=0, B=1, C=0). Reset takes priority over counting and holds the state for as long as it stays asserted.
- R2: Out of reset with the default, the code {A,B,C} steps once per rising edge through 2, 6, 1, 7, 5 and back to 2, with no end.
- R3: Flip-flop A has J tied to 1 and K equal to (not B) or (not C).
- R4: Flip-flop B has J tied to 1 and K equal to A.
- R5: Flip-flop C has J equal to A and K equal to A and (not B).
- R6: At each rising edge, every flip-flop acts on its J/K pair as follows: 00 holds, 01 clears, 10 sets, 11 inverts.
- R7: Unused code 0 moves to 6 on the next edge.
- R8: Unused code 3 moves to 7 on the next edge.
- R9: Unused code 4 moves to 3 on the next edge and then to 7 on the edge after that.
- R10: From any of the eight codes, the state lies in {1, 2, 5, 6, 7} after at most two rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; loads `RESET_CODE` |
| cnt_a | output | 1 | State bit A, most significant |
| cnt_b | output | 1 | State bit B |
| cnt_c | output | 1 | State bit C, least significant |

## Verification
Each next state is due exactly one rising edge after the state it comes from, because the outputs are the flip-flops themselves. The bench therefore drives reset and takes every sample on the falling edge, half a period after the edge that produced the value. The recovery path from code 4 needs two edges. For that path, the first sample after reset is released is checked against the intermediate code 3, and the second against 7. Reset is checked on the falling edge after the first edge that sees it high.

// File: rtl/jkc_pkg.sv
package jkc_pkg;
  localparam int CODE_W = 3;
  localparam int BIT_A  = 2;
  localparam int BIT_B  = 1;
  localparam int BIT_C  = 0;

  typedef logic [CODE_W-1:0] jkc_code_t;

  // Codes that belong to the main loop.
  function automatic logic on_loop(input jkc_code_t v);
    return (v == 3'd2) || (v == 3'd6) || (v == 3'd1) ||
           (v == 3'd7) || (v == 3'd5);
  endfunction
endpackage

// File: rtl/jkc_steer.sv
module jkc_steer
  import jkc_pkg::*;
(
  input  jkc_code_t cur,
  output jkc_code_t j_vec,
  output jkc_code_t k_vec
);
  logic qa, qb, qc;

  assign qa = cur[BIT_A];
  assign qb = cur[BIT_B];
  assign qc = cur[BIT_C];

  always_comb begin
    // R3: A sets freely and is released unless both B and C are high
    j_vec[BIT_A] = 1'b1;
    k_vec[BIT_A] = ~qb | ~qc;
    // R4: B sets freely and is released when A is high
    j_vec[BIT_B] = 1'b1;
    k_vec[BIT_B] = qa;
    // R5: C follows A on set, released when A high and B low
    j_vec[BIT_C] = qa;
    k_vec[BIT_C] = qa & ~qb;
  end
endmodule

// File: rtl/jk_flop.sv
module jk_flop #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else begin
      unique case ({j, k})
        2'b00:   q <= q;
        2'b01:   q <= 1'b0;
        2'b10:   q <= 1'b1;
        default: q <= ~q;
      endcase
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!j && !k) |=> $stable(q));
  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (!j && k) |=> !q);
  assert_set_R6: assert property (@(posedge clk) disable iff (rst)
    (j && !k) |=> q);
  assert_invert_R6: assert property (@(posedge clk) disable iff (rst)
    (j && k) |=> (q != $past(q)));
endmodule

// File: rtl/jkc_counter.sv
module jkc_counter
  import jkc_pkg::*;
#(
  parameter jkc_code_t RESET_CODE = 3'd2
) (
  input  logic clk,
  input  logic rst,
  output logic cnt_a,
  output logic cnt_b,
  output logic cnt_c
);
  jkc_code_t st;
  jkc_code_t j_vec;
  jkc_code_t k_vec;

  jkc_steer u_steer (
    .cur   (st),
    .j_vec (j_vec),
    .k_vec (k_vec)
  );

  for (genvar i = 0; i < CODE_W; i++) begin : g_ff
    jk_flop #(.RST_VAL(RESET_CODE[i])) u_ff (
      .clk (clk),
      .rst (rst),
      .j   (j_vec[i]),
      .k   (k_vec[i]),
      .q   (st[i])
    );
  end

  assign cnt_a = st[BIT_A];
  assign cnt_b = st[BIT_B];
  assign cnt_c = st[BIT_C];

  // R2: main loop order
  assert_step2_R2: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd2) |=> (st == 3'd6));
  assert_step6_R2: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd6) |=> (st == 3'd1));
  assert_step1_R2: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd1) |=> (st == 3'd7));
  assert_step7_R2: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd7) |=> (st == 3'd5));
  assert_step5_R2: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd5) |=> (st == 3'd2));
  // R7, R8, R9: unused codes
  assert_from0_R7: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd0) |=> (st == 3'd6));
  assert_from3_R8: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd3) |=> (st == 3'd7));
  assert_from4_R9: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd4) |=> (st == 3'd3));
  // R10: leaving an unused code lands on the loop or on 3, and 3 lands on the loop
  assert_recover_R10: assert property (@(posedge clk) disable iff (rst)
    !on_loop(st) |=> (on_loop(st) || st == 3'd3));
  assert_recover3_R10: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd3) |=> on_loop(st));
endmodule

// File: tb/jkc_counter_tb.sv
module jkc_counter_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ma, mb, mc;
  wire [23:0] alt_flat;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  jkc_counter u_dut (.clk(clk), .rst(rst), .cnt_a(ma), .cnt_b(mb), .cnt_c(mc));

  for (genvar g = 0; g < 8; g++) begin : g_alt
    jkc_counter #(.RESET_CODE(3'(g))) u_alt (
      .clk   (clk),
      .rst   (rst),
      .cnt_a (alt_flat[3*g+2]),
      .cnt_b (alt_flat[3*g+1]),
      .cnt_c (alt_flat[3*g])
    );
  end

  // {start, after one edge, after two edges}
  localparam logic [8:0] TBL [8] = '{
    {3'd0, 3'd6, 3'd1}, {3'd1, 3'd7, 3'd5},
    {3'd2, 3'd6, 3'd1}, {3'd3, 3'd7, 3'd5},
    {3'd4, 3'd3, 3'd7}, {3'd5, 3'd2, 3'd6},
    {3'd6, 3'd1, 3'd7}, {3'd7, 3'd5, 3'd2}
  };

  function automatic bit loop_code(input logic [2:0] v);
    return v == 3'd1 || v == 3'd2 || v == 3'd5 || v == 3'd6 || v == 3'd7;
  endfunction

  function automatic string step_req(input logic [2:0] s);
    case (s)
      3'd0: return "R7";
      3'd3: return "R8";
      3'd4: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [2:0] exp_m;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset values, including every alternate reset code
    chk("R1", {ma, mb, mc}, 3'd2);
    for (int k = 0; k < 8; k++) chk("R1", alt_flat[3*k +: 3], TBL[k][8:6]);
    rst = 1'b0;

    // Table walk: first step (R3, R4, R5, R6 via each code's successor)
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      chk(step_req(TBL[k][8:6]), alt_flat[3*k +: 3], TBL[k][5:3]);
      chk("R6", alt_flat[3*k +: 3], TBL[k][5:3]);
    end
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      chk(TBL[k][8:6] == 3'd4 ? "R9" : "R2", alt_flat[3*k +: 3], TBL[k][2:0]);
      chk("R10", {2'b00, loop_code(alt_flat[3*k +: 3])}, 3'd1);
    end

    // Main instance: loop continues (R2) with A, B, C equations (R3 R4 R5)
    exp_m = 3'd1;
    chk("R2", {ma, mb, mc}, exp_m);
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      case (exp_m)
        3'd2: exp_m = 3'd6;
        3'd6: exp_m = 3'd1;
        3'd1: exp_m = 3'd7;
        3'd7: exp_m = 3'd5;
        default: exp_m = 3'd2;
      endcase
      chk("R2", {ma, mb, mc}, exp_m);
    end

    // R1: mid-run reset has priority and holds
    rst = 1'b1;
    @(negedge clk);
    chk("R1", {ma, mb, mc}, 3'd2);
    chk("R1", alt_flat[3*4 +: 3], 3'd4);
    @(negedge clk);
    chk("R1", {ma, mb, mc}, 3'd2);
    rst = 1'b0;
    @(negedge clk);
    chk("R2", {ma, mb, mc}, 3'd6);
    chk("R9", alt_flat[3*4 +: 3], 3'd3);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule